// File: doc/BRIEF.md
# Quad-channel double-data-rate output multiplexer

This block takes four 12-bit converter results and places them on two 12-bit output buses. In quad mode, each bus carries two channels per sample clock, one in each clock phase. Bus A carries channel 0 during the high phase and channel 1 during the low phase. Bus B carries channel 2 during the high phase and channel 3 during the low phase. For a 40 MHz sample clock, each bus therefore runs at an 80 MHz word rate.

The same pins also serve a single-channel mode. In that mode bus A holds one 12-bit code for the whole clock period. The two least significant bits of bus B hold a 2-bit range tag, and the upper bits of bus B are zero.

All inputs are captured together on the rising edge, so the two words sent on a bus in one period belong to the same sample instant. A per-channel enable forces the slot of an unused channel to zero. The pad drivers and the converters sit outside this block.

Top module: `qddr_out_mux`

## Requirements
- R1: While `rst_n` is low, and in the first period after it, both buses read zero in both clock phases.
- R2: In quad mode (`quad_mode`=1), bus A shows channel 0 while `clk` is high and channel 1 while `clk` is low.
- R3: In quad mode, bus B shows channel 2 while `clk` is high and channel 3 while `clk` is low.
- R4: All channel inputs are captured on the same rising edge. An input change made after that edge does not reach either bus before the next rising edge, including in the following low phase.
- R5: Bit i of `ch_en` enables channel i (1 = enabled). The slot of a disabled channel reads zero.
- R6: In single-channel mode (`quad_mode`=0), bus A shows the channel 0 code, masked by `ch_en[0]`, in both clock phases.
- R7: In single-channel mode, `bus_b[1:0]` equals `rng_tag` and `bus_b[11:2]` is zero, in both clock phases.
- R8: `quad_mode` is captured on the rising edge together with the data. A mode change made mid-period takes effect only from the next rising edge.
- R9: Channel i occupies `ch_data[12*i+11 : 12*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock. Its level also selects the half-word on each bus. |
| rst_n | input | 1 | Asynchronous active-low reset. |
| quad_mode | input | 1 | 1 selects quad mode; 0 selects single-channel mode. |
| ch_en | input | 4 | Per-channel enable, bit i for channel i. |
| ch_data | input | 48 | Four packed 12-bit codes, channel 0 in the low bits. |
| rng_tag | input | 2 | Range tag sent in single-channel mode. |
| bus_a | output | 12 | Output bus for channels 0 and 1, or the single code. |
| bus_b | output | 12 | Output bus for channels 2 and 3, or the range tag. |

## Verification
The hardest situation to reach is an input or mode change that lands in the high phase, after the capture edge. A faulty design that passes data straight through, or that captures on the falling edge, would only show the new value in the following low phase.

The bench covers this with a directed step. It samples the high phase, changes every channel word and flips `quad_mode` while `clk` is still high, then checks that the low phase still presents the old channel 1 and channel 3 words in quad form. The vector table alternates modes and enable masks. It uses all-ones against all-zeros words and single-bit extremes, so a swapped slot or a wrong phase polarity shows up as a mismatch.

// File: rtl/qddr_pkg.sv
package qddr_pkg;
  localparam int unsigned CODE_W = 12;
  localparam int unsigned NCH    = 4;
  localparam int unsigned RNG_W  = 2;
  localparam int unsigned BUS_W  = NCH * CODE_W;

  typedef enum logic {
    MODE_SINGLE = 1'b0,
    MODE_QUAD   = 1'b1
  } mode_e;

  // Zero a code when its channel is switched off.
  function automatic logic [CODE_W-1:0] gate_code(input logic [CODE_W-1:0] code,
                                                   input logic on);
    return on ? code : '0;
  endfunction

  // Place the range tag in the low bits of a bus word, rest zero.
  function automatic logic [CODE_W-1:0] tag_word(input logic [RNG_W-1:0] tag);
    logic [CODE_W-1:0] w;
    w = '0;
    w[RNG_W-1:0] = tag;
    return w;
  endfunction
endpackage

// File: rtl/qddr_capture.sv
module qddr_capture
  import qddr_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] gated;

  always_comb gated = en ? d : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= gated;
  end

  // R5
  dis_slot_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(en)) |-> (q == '0));

  // R4
  cap_same_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(en)) |-> (q == $past(d)));
endmodule

// File: rtl/qddr_slot_sel.sv
module qddr_slot_sel
  import qddr_pkg::*;
#(
  parameter int unsigned W = CODE_W,
  parameter int unsigned RW = RNG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_q,
  input  logic [RW-1:0] tag_q,
  input  logic [W-1:0]  c0,
  input  logic [W-1:0]  c1,
  input  logic [W-1:0]  c2,
  input  logic [W-1:0]  c3,
  output logic [W-1:0]  a_hi,
  output logic [W-1:0]  a_lo,
  output logic [W-1:0]  b_hi,
  output logic [W-1:0]  b_lo
);
  always_comb begin
    if (mode_q == MODE_QUAD) begin
      a_hi = c0;
      a_lo = c1;
      b_hi = c2;
      b_lo = c3;
    end else begin
      a_hi = c0;
      a_lo = c0;
      b_hi = tag_word(tag_q);
      b_lo = tag_word(tag_q);
    end
  end

  // R6
  single_flat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SINGLE) |-> (a_hi == a_lo));

  // R7
  tag_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_SINGLE) |-> ((b_hi[W-1:RW] == '0) && (b_lo == b_hi)));
endmodule

// File: rtl/qddr_phase_mux.sv
module qddr_phase_mux
  import qddr_pkg::*;
#(
  parameter int unsigned W = CODE_W
) (
  input  logic         clk,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  output logic [W-1:0] y
);
  always_comb y = clk ? hi : lo;
endmodule

// File: rtl/qddr_out_mux.sv
module qddr_out_mux
  import qddr_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                quad_mode,
  input  logic [NCH-1:0]      ch_en,
  input  logic [BUS_W-1:0]    ch_data,
  input  logic [RNG_W-1:0]    rng_tag,
  output logic [CODE_W-1:0]   bus_a,
  output logic [CODE_W-1:0]   bus_b
);
  logic [CODE_W-1:0] cap [NCH];
  logic              mode_q;
  logic [RNG_W-1:0]  tag_q;
  logic [CODE_W-1:0] a_hi, a_lo, b_hi, b_lo;

  // R9: channel i sits at ch_data[CODE_W*i +: CODE_W]
  for (genvar i = 0; i < NCH; i++) begin : g_cap
    qddr_capture #(.W(CODE_W)) u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (ch_en[i]),
      .d     (ch_data[CODE_W*i +: CODE_W]),
      .q     (cap[i])
    );
  end

  // R8: mode and tag share the data capture edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_QUAD;
      tag_q  <= '0;
    end else begin
      mode_q <= quad_mode;
      tag_q  <= rng_tag;
    end
  end

  qddr_slot_sel #(.W(CODE_W), .RW(RNG_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_q (mode_q),
    .tag_q  (tag_q),
    .c0     (cap[0]),
    .c1     (cap[1]),
    .c2     (cap[2]),
    .c3     (cap[3]),
    .a_hi   (a_hi),
    .a_lo   (a_lo),
    .b_hi   (b_hi),
    .b_lo   (b_lo)
  );

  qddr_phase_mux #(.W(CODE_W)) u_mux_a (.clk(clk), .hi(a_hi), .lo(a_lo), .y(bus_a));
  qddr_phase_mux #(.W(CODE_W)) u_mux_b (.clk(clk), .hi(b_hi), .lo(b_lo), .y(bus_b));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (a_hi == '0 && a_lo == '0 && b_lo == '0));
endmodule

// File: tb/qddr_out_mux_tb.sv
module qddr_out_mux_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        quad_mode = 1'b1;
  logic [3:0]  ch_en = 4'hF;
  logic [47:0] ch_data = '0;
  logic [1:0]  rng_tag = '0;
  logic [11:0] bus_a, bus_b;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  qddr_out_mux u_dut (
    .clk(clk), .rst_n(rst_n), .quad_mode(quad_mode), .ch_en(ch_en),
    .ch_data(ch_data), .rng_tag(rng_tag), .bus_a(bus_a), .bus_b(bus_b)
  );

  // {mode, en[3:0], tag[1:0], d3, d2, d1, d0}
  localparam int NV = 10;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 4'hF, 2'd0, 12'hABC, 12'h456, 12'h789, 12'h123},
    {1'b1, 4'hF, 2'd0, 12'hFFF, 12'h000, 12'hFFF, 12'h000},
    {1'b1, 4'h5, 2'd0, 12'h111, 12'h222, 12'h333, 12'h444},
    {1'b1, 4'hA, 2'd0, 12'hAAA, 12'h555, 12'hCCC, 12'h333},
    {1'b0, 4'hF, 2'd3, 12'h111, 12'h222, 12'h333, 12'h7E5},
    {1'b0, 4'hF, 2'd1, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF},
    {1'b0, 4'hE, 2'd2, 12'h999, 12'h888, 12'h777, 12'h5A5},
    {1'b1, 4'h0, 2'd3, 12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF},
    {1'b0, 4'hF, 2'd0, 12'hFFF, 12'hFFF, 12'hFFF, 12'h000},
    {1'b1, 4'hF, 2'd0, 12'h800, 12'h001, 12'h800, 12'h001}
  };

  function automatic logic [11:0] word(input logic [54:0] v, input int ch);
    return v[50+ch] ? v[12*ch +: 12] : 12'h000;
  endfunction

  // Expected bus value: bus 0 = A, 1 = B; hi = clock-high phase.
  function automatic logic [11:0] expect_bus(input logic [54:0] v, input int bus, input bit hi);
    if (v[54]) return word(v, bus*2 + (hi ? 0 : 1));
    if (bus == 0) return word(v, 0);
    return {10'b0, v[49:48]};
  endfunction

  task automatic chk(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic drive(input logic [54:0] v);
    quad_mode = v[54];
    ch_en     = v[53:50];
    rng_tag   = v[49:48];
    ch_data   = v[47:0];
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [54:0] vx, vy;
    // R1: reset with busy inputs
    drive(VEC[0]);
    @(posedge clk); #2;
    chk("R1 bus_a hi in reset", bus_a, 12'h000);
    chk("R1 bus_b hi in reset", bus_b, 12'h000);
    @(negedge clk); #1;
    chk("R1 bus_a lo in reset", bus_a, 12'h000);
    chk("R1 bus_b lo in reset", bus_b, 12'h000);
    rst_n = 1'b1;

    // Table walk: R2 R3 R5 R6 R7 R9
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k]);
      @(posedge clk); #2;
      chk(VEC[k][54] ? "R2/R5/R9 bus_a hi" : "R6 bus_a hi", bus_a, expect_bus(VEC[k], 0, 1));
      chk(VEC[k][54] ? "R3/R5 bus_b hi" : "R7 bus_b hi", bus_b, expect_bus(VEC[k], 1, 1));
      @(negedge clk); #1;
      chk(VEC[k][54] ? "R2/R5 bus_a lo" : "R6 bus_a lo", bus_a, expect_bus(VEC[k], 0, 0));
      chk(VEC[k][54] ? "R3/R5 bus_b lo" : "R7 bus_b lo", bus_b, expect_bus(VEC[k], 1, 0));
    end

    // R4 / R8: change data and mode in the high phase after capture
    vx = {1'b1, 4'hF, 2'd0, 12'h3C3, 12'h0F0, 12'hC3C, 12'h5AA};
    vy = {1'b0, 4'hF, 2'd2, 12'h111, 12'h222, 12'h333, 12'h444};
    drive(vx);
    @(posedge clk); #2;
    chk("R2 bus_a hi before late change", bus_a, 12'h5AA);
    drive(vy);
    @(negedge clk); #1;
    chk("R4 bus_a lo keeps captured ch1", bus_a, 12'hC3C);
    chk("R8 bus_b lo keeps quad ch3", bus_b, 12'h3C3);
    @(posedge clk); #2;
    chk("R8 bus_a single after next edge", bus_a, 12'h444);
    chk("R8 bus_b tag after next edge", bus_b, 12'h002);

    // R1: reset mid-run clears both phases
    drive(VEC[0]);
    @(negedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk("R1 bus_a lo after reset", bus_a, 12'h000);
    @(posedge clk); #2;
    chk("R1 bus_b hi after reset", bus_b, 12'h000);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 bus_a lo first period", bus_a, 12'h000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule